// File: doc/BRIEF.md
# Event and Alarm Interrupt Unit

This block turns two interrupt sources into one shared, active-low, open-drain interrupt pin. The first source is an external event input, where a high level means an event. The second is a single-cycle request from a timer alarm comparator. Each source sets its own sticky status flag, so the host can read which one fired. The output is a pull-low enable for the pad: 1 means drive the pin low, 0 means release it.

The event input is asynchronous. It passes through a synchronizer, and only its rising edge counts. A control bit turns event sensing on or off. A second control bit decides whether sensing stays on while the device runs from its backup supply, which the `backup_i` flag reports. A separate enable lets an alarm pull the pin. The host reaches the control and status bits through a small word-wide register port. Reads are combinational. Writes to status are write-one-to-clear.

Top module: `evt_irq_unit`

## Requirements
- R1: After reset, control and status are all zero, `irq_pull_o` is 0 (pin released), and every read returns 0.
- R2: Register map. Offset 0 is control: bit 0 event enable, bit 1 keep-sensing-in-backup, bit 2 alarm interrupt enable. Offset 1 is status: bit 0 alarm flag, bit 1 event flag. Offsets 2 and 3 read as 0. Control reads back what was written.
- R3: `evt_i` goes high and is sampled at clock edge k. With sensing active, the event flag reads 1 after edge k+2, because of two synchronizer flops plus one edge-detect flop.
- R4: An event input held high sets the event flag only once. After the flag is cleared, the level that is still held does not set it again. Only a new rising edge does.
- R5: With event enable at 0, the event input has no effect. Turning the enable on while the input is already high does not set the flag.
- R6: Sensing is active only when the event enable is 1 and either `backup_i` is 0 or the keep-sensing-in-backup bit is 1.
- R7: A cycle with `alarm_pulse_i` high sets the alarm flag on that edge, whatever the enables are.
- R8: `irq_pull_o` is 1 exactly when (event flag AND event enable) OR (alarm flag AND alarm interrupt enable). The pin stays low until software clears the flag.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R10: If a flag's set condition and its clear land on the same edge, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | Asynchronous external event level (high = event) |
| alarm_pulse_i | input | 1 | One-cycle alarm request |
| backup_i | input | 1 | Device is running from its backup supply |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Combinational read data |
| irq_pull_o | output | 1 | 1 = drive the shared interrupt pin low |

## Verification
The hardest case to reach is a new event edge that lands on the same clock edge as a write-one-to-clear of an event flag that is already set. Through the ports, this needs an exact count of the synchronizer and edge-detect delay. The stimulus first sets and holds the flag with an earlier edge, then drops the input. It raises the input again and issues the clear write two negative edges later, so that both land on the same edge. The sweep over all sixteen combinations of the three control bits and the backup flag covers the gating for every mode.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned SYNC_N  = 2;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 2'd1;

  localparam int unsigned CB_EVT_EN = 0;
  localparam int unsigned CB_BKP_EN = 1;
  localparam int unsigned CB_ALM_IE = 2;
  localparam int unsigned SB_ALM    = 0;
  localparam int unsigned SB_EVT    = 1;

  typedef struct packed {
    logic alm_ie;
    logic bkp_en;
    logic evt_en;
  } ctrl_t;
endpackage

// File: rtl/evt_irq_sync.sv
module evt_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/evt_irq_flags.sv
module evt_irq_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_evt_i,
  input  logic set_alm_i,
  input  logic clr_evt_i,
  input  logic clr_alm_i,
  output logic evt_flag_o,
  output logic alm_flag_o
);
  logic evt_q, alm_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q <= 1'b0;
      alm_q <= 1'b0;
    end else begin
      if (set_evt_i)      evt_q <= 1'b1;
      else if (clr_evt_i) evt_q <= 1'b0;
      if (set_alm_i)      alm_q <= 1'b1;
      else if (clr_alm_i) alm_q <= 1'b0;
    end
  end

  assign evt_flag_o = evt_q;
  assign alm_flag_o = alm_q;

  // R9
  evt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q && !clr_evt_i |=> evt_q);
  // R7
  alm_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_alm_i |=> alm_q);
  // R10
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_evt_i && clr_evt_i |=> evt_q);
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic              alarm_pulse_i,
  input  logic              backup_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_pull_o
);
  ctrl_t ctrl_q;
  logic  evt_sync, evt_prev_q, evt_rise, evt_active;
  logic  evt_flag, alm_flag;
  logic  wr_ctrl, wr_stat;
  logic  unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:3];
  assign wr_ctrl = reg_we_i && (reg_addr_i == OFS_CTRL);
  assign wr_stat = reg_we_i && (reg_addr_i == OFS_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_ctrl) begin
      ctrl_q.evt_en <= reg_wdata_i[CB_EVT_EN];
      ctrl_q.bkp_en <= reg_wdata_i[CB_BKP_EN];
      ctrl_q.alm_ie <= reg_wdata_i[CB_ALM_IE];
    end
  end

  evt_irq_sync #(.STAGES(SYNC_N)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (evt_i),
    .q_o   (evt_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) evt_prev_q <= 1'b0;
    else         evt_prev_q <= evt_sync;

  assign evt_rise   = evt_sync && !evt_prev_q;
  assign evt_active = ctrl_q.evt_en && (!backup_i || ctrl_q.bkp_en);

  evt_irq_flags flags_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_evt_i (evt_rise && evt_active),
    .set_alm_i (alarm_pulse_i),
    .clr_evt_i (wr_stat && reg_wdata_i[SB_EVT]),
    .clr_alm_i (wr_stat && reg_wdata_i[SB_ALM]),
    .evt_flag_o(evt_flag),
    .alm_flag_o(alm_flag)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_CTRL: begin
        reg_rdata_o[CB_EVT_EN] = ctrl_q.evt_en;
        reg_rdata_o[CB_BKP_EN] = ctrl_q.bkp_en;
        reg_rdata_o[CB_ALM_IE] = ctrl_q.alm_ie;
      end
      OFS_STAT: begin
        reg_rdata_o[SB_ALM] = alm_flag;
        reg_rdata_o[SB_EVT] = evt_flag;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_pull_o = (evt_flag && ctrl_q.evt_en) || (alm_flag && ctrl_q.alm_ie);

  // R5
  // R6
  evt_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_flag) |-> $past(evt_active));
  // R8
  pin_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_flag && !alm_flag |-> !irq_pull_o);
  // R4
  single_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_flag) |-> $past(!evt_prev_q));
endmodule

// File: tb/evt_irq_unit_tb.sv
module evt_irq_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt = 1'b0, alm = 1'b0, bkp = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       pull;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  evt_irq_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .alarm_pulse_i(alm),
    .backup_i(bkp), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_pull_o(pull)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = 8'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    #5;
    // R1 reset state
    #1; chk("R1 pull in reset", pull, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], r); chk("R1 read after reset", r, 0);
    end
    chk("R1 pull after reset", pull, 0);

    // R2 control readback and unused offsets
    wr(2'd0, 8'hFF); rd(2'd0, r); chk("R2 ctrl readback", r, 7);
    wr(2'd0, 8'h05); rd(2'd0, r); chk("R2 ctrl readback", r, 5);
    rd(2'd2, r); chk("R2 offset2", r, 0);
    rd(2'd3, r); chk("R2 offset3", r, 0);

    // R3 exact latency: flag appears after edge k+2
    wr(2'd0, 8'h01); bkp = 1'b0;
    @(negedge clk); evt = 1'b1; addr = 2'd1;
    @(negedge clk); #1; chk("R3 not yet after k", rdata[1], 0);
    @(negedge clk); #1; chk("R3 not yet after k+1", rdata[1], 0);
    @(negedge clk); #1; chk("R3 set after k+2", rdata[1], 1);
    chk("R8 pin low on event", pull, 1);

    // R4 held level does not re-set after clear
    wr(2'd1, 8'h02); idle(5); rd(2'd1, r); chk("R4 no re-set on held level", r, 0);
    chk("R8 pin released after clear", pull, 0);
    evt = 1'b0; idle(4);

    // R10 new edge concurrent with clear of a set flag
    evt = 1'b1; idle(4); evt = 1'b0; idle(4);
    rd(2'd1, r); chk("R10 precondition", r, 2);
    @(negedge clk); evt = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = 2'd1; wdata = 8'h02;
    @(negedge clk); we = 1'b0; wdata = 8'd0; #1;
    chk("R10 event beats clear", rdata[1], 1);
    evt = 1'b0; idle(4);
    // R10 alarm and clear together
    @(negedge clk); alm = 1'b1; we = 1'b1; addr = 2'd1; wdata = 8'h01;
    @(negedge clk); alm = 1'b0; we = 1'b0; wdata = 8'd0; #1;
    chk("R10 alarm beats clear", rdata[0], 1);
    wr(2'd1, 8'h03); rd(2'd1, r); chk("R9 clear both", r, 0);

    // R5 gated off, enabling during held level does not fire
    wr(2'd0, 8'h00); evt = 1'b1; idle(5);
    rd(2'd1, r); chk("R5 gated event", r, 0);
    wr(2'd0, 8'h01); idle(5);
    rd(2'd1, r); chk("R5 enable during held level", r, 0);
    evt = 1'b0; idle(4); evt = 1'b1; idle(4);
    rd(2'd1, r); chk("R5 new edge after enable", r, 2);
    evt = 1'b0; idle(4); wr(2'd1, 8'h02);

    // Sweep all control/backup combinations
    for (int c = 0; c < 16; c++) begin
      automatic bit en  = c[0];
      automatic bit ben = c[1];
      automatic bit aie = c[2];
      automatic bit bk  = c[3];
      automatic bit ef  = en && (!bk || ben);
      wr(2'd0, {5'd0, aie, ben, en});
      bkp = bk;
      wr(2'd1, 8'h03);
      evt = 1'b1; idle(4);
      rd(2'd1, r); chk("R6 event gating", r[1], ef);
      chk("R8 pin after event", pull, ef && en);
      @(negedge clk); alm = 1'b1;
      @(negedge clk); alm = 1'b0; #1;
      chk("R7 alarm flag", rdata[0], 1);
      chk("R8 pin after alarm", pull, (ef && en) || aie);
      wr(2'd1, 8'h00); rd(2'd1, r);
      chk("R9 write zero keeps", r, {ef, 1'b1});
      wr(2'd1, 8'h02); rd(2'd1, r);
      chk("R9 clear event only", r, 1);
      chk("R8 pin after event clear", pull, aie);
      wr(2'd1, 8'h01); rd(2'd1, r);
      chk("R9 clear alarm", r, 0);
      chk("R8 pin idle", pull, 0);
      evt = 1'b0; idle(4);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule